// File: doc/BRIEF.md
# Instruction Prefetch Queue with Port Arbiter

This block sits between a single-ported unified cache and an instruction decoder. It keeps a 32-byte circular queue of instruction bytes filled by reading aligned 16-byte blocks through the shared cache port. The decoder reads only from this queue. Each cycle the decoder sees how many bytes are valid and a window of up to 8 bytes starting at the oldest byte. It then tells the block how many of those bytes it consumed.

The execute stage has priority on the cache port. It raises `data_pend_i` one cycle before it uses the port, and in that following cycle the prefetcher does not request. A taken branch raises `redir_i` with a target address. In that cycle the queue is emptied and any line still returning from the old path is dropped. The cycle belongs to the branch, so the prefetcher uses it to request the block that holds the target. When the target is not 16-byte aligned, only the bytes from the target offset to the end of the block enter the queue.

The fetch engine is a state machine with three states:
- **FS_IDLE**: the state after reset. No address is known and nothing is requested.
- **FS_TARGET**: the request for a redirect target has been refused by a busy port. The request is retried with the same block and offset.
- **FS_STREAM**: sequential blocks are fetched.

Transitions:
- **redirect-accepted**: any state to FS_STREAM, when `redir_i` is high and the port is not busy.
- **redirect-refused**: any state to FS_TARGET, when `redir_i` is high and the port is busy.
- **target-accepted**: FS_TARGET to FS_STREAM.
- **target-retry**: FS_TARGET to itself.
- **stream-continue**: FS_STREAM to itself.
- **idle-wait**: FS_IDLE to itself until the first redirect.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, `avail_o` is 0 and `ic_req_o` is low.
- R2: `ic_addr_o` always has its low 4 bits at zero. After each accepted request (`ic_req_o` high and `ic_busy_i` low), the next fetch address is the previous one plus 16.
- R3: In FS_STREAM, a request is made only if at least 16 bytes are free. Free bytes are 32 minus the queued bytes minus the bytes of the line returning in the current cycle. The queue never holds more than 32 bytes.
- R4: In the cycle after `data_pend_i` is high, `ic_req_o` is low, unless `redir_i` is high in that cycle.
- R5: In a cycle with `redir_i` high:
  - `ic_req_o` is high and `ic_addr_o` is the target with its low 4 bits cleared, whatever the queue level or data slot.
  - A line returning in the same cycle is discarded.
  - `avail_o` reads 0 in the next cycle.
- R6: A line requested at a target with offset o (its low 4 bits) adds 16−o bytes to the queue. Those bytes are line bytes o..15. A sequential line adds all 16 bytes. Byte j of a line is `ic_rdata_i[8j+7:8j]`.
- R7: Byte k of `win_o` (bits 8k+7:8k) is the k-th oldest queued byte, for k below `avail_o`.
- R8: `take_i` (0..8, never above `avail_o`) removes that many of the oldest bytes. Queue positions wrap modulo 32. `take_i` is ignored in a redirect cycle.
- R9: A request refused by `ic_busy_i` is presented again with the same address in the next cycle, so no block is skipped.
- R10: A refused redirect request is retried while in FS_TARGET. The retry keeps the target block and offset and still gives way to announced data cycles. Once it is accepted, the next address is the target block plus 16.
- R11: Before the first redirect after reset, no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_i | input | 1 | Taken branch: flush the queue and redirect fetch |
| redir_addr_i | input | 32 | Branch target byte address |
| data_pend_i | input | 1 | Execute stage uses the cache port in the next cycle |
| ic_req_o | output | 1 | Line read request to the cache |
| ic_addr_o | output | 32 | Aligned line address |
| ic_busy_i | input | 1 | Cache refuses the request this cycle |
| ic_rvalid_i | input | 1 | Line data valid, one cycle after acceptance |
| ic_rdata_i | input | 128 | Line data, byte j in bits 8j+7:8j |
| avail_o | output | 6 | Number of valid queued bytes |
| win_o | output | 64 | Oldest 8 queued bytes, oldest in the low byte |
| take_i | input | 4 | Bytes consumed by the decoder this cycle |

## Verification
The fetch engine is first driven with the port always free and the decoder stalled, which shows where the queue stops filling. Varying consume rates then show sustained streaming and pointer wrap. Random data announcements separate correct yielding from prefetches that collide with execute-stage accesses. Random busy cycles show whether the fetch position is held or lost under refusal. Redirects are applied to unaligned targets, while a line is in flight, and while the port is busy. These cases tell apart correct partial-line insertion, stale-data discard and the retry path of FS_TARGET.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    // Fetch engine states
    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_TARGET = 2'd1,
        FS_STREAM = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/pfq_ring.sv
// Circular byte store: partial-line writes at the write pointer, a read window at the read pointer.
// DEPTH and LINE must be powers of two.
module pfq_ring #(
    parameter int DEPTH = 32,
    parameter int LINE  = 16,
    parameter int WIN   = 8,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int OFF_W  = $clog2(LINE),
    localparam int TAKE_W = $clog2(WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [LINE*8-1:0] wr_data_i,
    input  logic [TAKE_W-1:0] take_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [WIN*8-1:0]  win_o
);

    logic [7:0]       mem     [DEPTH];
    logic [PTR_W-1:0] rptr_q;
    logic [PTR_W-1:0] wptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wr_n;
    logic [PTR_W-1:0] rel_a   [DEPTH];
    logic [DEPTH-1:0] slot_we;
    logic [7:0]       slot_byte [DEPTH];

    assign wr_n    = CNT_W'(LINE) - CNT_W'(wr_off_i);
    assign count_o = cnt_q;

    // Per-slot write decode: slot i receives line byte (offset + distance from write pointer)
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rel_a[i]     = PTR_W'(i) - wptr_q;
            slot_we[i]   = wr_en_i && !clear_i && (CNT_W'(rel_a[i]) < wr_n);
            slot_byte[i] = wr_data_i[8*((int'(wr_off_i) + int'(rel_a[i])) & (LINE-1)) +: 8];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
                mem[i] <= slot_byte[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (clear_i) begin
            rptr_q <= '0;
            wptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            rptr_q <= rptr_q + PTR_W'(take_i);
            if (wr_en_i) begin
                wptr_q <= wptr_q + PTR_W'(wr_n);
            end
            cnt_q <= cnt_q - CNT_W'(take_i) + (wr_en_i ? wr_n : '0);
        end
    end

    // Decoder window
    for (genvar k = 0; k < WIN; k++) begin : g_win
        assign win_o[8*k +: 8] = mem[rptr_q + PTR_W'(k)];
    end

    // R8: decoder never consumes more than is queued
    a_r8_take_within: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> (CNT_W'(take_i) <= cnt_q));

    // R3: an accepted line always fits
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i) |-> (int'(cnt_q) - int'(take_i) + int'(wr_n) <= DEPTH));

endmodule

// File: rtl/pfq_arb.sv
// Fetch engine: port arbitration against announced data cycles, redirect handling, fetch address.
module pfq_arb
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int LINE   = 16,
    localparam int OFF_W = $clog2(LINE),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] redir_addr_i,
    input  logic              data_pend_i,
    input  logic              busy_i,
    input  logic              rvalid_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [OFF_W-1:0]  wr_off_o
);

    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] faddr_q;
    logic [OFF_W-1:0]  tgt_off_q;
    logic              slot_q;
    logic              infl_q;
    logic [OFF_W-1:0]  infl_off_q;

    logic [ADDR_W-1:0] blk;
    logic [OFF_W-1:0]  off_sel;
    logic              accept;
    logic              room_ok;
    int                pend;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (redir_i) begin
            state_d = accept ? FS_STREAM : FS_TARGET;
        end else begin
            unique case (state_q)
                FS_IDLE:   state_d = FS_IDLE;
                FS_TARGET: state_d = accept ? FS_STREAM : FS_TARGET;
                FS_STREAM: state_d = FS_STREAM;
                default:   state_d = FS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        blk     = {redir_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        pend    = infl_q ? (LINE - int'(infl_off_q)) : 0;
        room_ok = (DEPTH - int'(count_i) - pend) >= LINE;
        req_o   = 1'b0;
        unique case (state_q)
            FS_IDLE:   req_o = 1'b0;
            FS_TARGET: req_o = !slot_q;
            FS_STREAM: req_o = !slot_q && room_ok;
            default:   req_o = 1'b0;
        endcase
        if (redir_i) begin
            // the branch's own data slot carries the target fetch
            req_o   = 1'b1;
            addr_o  = blk;
            off_sel = redir_addr_i[OFF_W-1:0];
        end else begin
            addr_o  = faddr_q;
            off_sel = (state_q == FS_TARGET) ? tgt_off_q : '0;
        end
        accept   = req_o && !busy_i;
        wr_en_o  = rvalid_i && infl_q && !redir_i;
        wr_off_o = infl_off_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            faddr_q    <= '0;
            tgt_off_q  <= '0;
            slot_q     <= 1'b0;
            infl_q     <= 1'b0;
            infl_off_q <= '0;
        end else begin
            if (redir_i) begin
                faddr_q   <= accept ? (blk + ADDR_W'(LINE)) : blk;
                tgt_off_q <= redir_addr_i[OFF_W-1:0];
            end else if (accept) begin
                faddr_q   <= faddr_q + ADDR_W'(LINE);
            end
            slot_q     <= data_pend_i;
            infl_q     <= accept;
            infl_off_q <= off_sel;
        end
    end

    // R4: announced data cycle is never taken by a prefetch
    a_r4_yield: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(data_pend_i) && !redir_i) |-> !req_o);

    // R2 / R10: accepted request moves the fetch position by one line
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !busy_i) |=> (redir_i || addr_o == $past(addr_o) + ADDR_W'(LINE)));

    // R9: refused request keeps its position
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && busy_i) |=> (redir_i || addr_o == $past(addr_o)));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int LINE   = 16,
    parameter int WIN    = 8,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int OFF_W  = $clog2(LINE),
    localparam int TAKE_W = $clog2(WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_i,
    input  logic [ADDR_W-1:0] redir_addr_i,
    input  logic              data_pend_i,
    output logic              ic_req_o,
    output logic [ADDR_W-1:0] ic_addr_o,
    input  logic              ic_busy_i,
    input  logic              ic_rvalid_i,
    input  logic [LINE*8-1:0] ic_rdata_i,
    output logic [CNT_W-1:0]  avail_o,
    output logic [WIN*8-1:0]  win_o,
    input  logic [TAKE_W-1:0] take_i
);

    logic             wr_en;
    logic [OFF_W-1:0] wr_off;
    logic [CNT_W-1:0] count;
    logic [TAKE_W-1:0] take_eff;

    // R8: consumption is ignored during a redirect
    assign take_eff = redir_i ? '0 : take_i;
    assign avail_o  = count;

    pfq_arb #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .LINE   (LINE)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .redir_i      (redir_i),
        .redir_addr_i (redir_addr_i),
        .data_pend_i  (data_pend_i),
        .busy_i       (ic_busy_i),
        .rvalid_i     (ic_rvalid_i),
        .count_i      (count),
        .req_o        (ic_req_o),
        .addr_o       (ic_addr_o),
        .wr_en_o      (wr_en),
        .wr_off_o     (wr_off)
    );

    pfq_ring #(
        .DEPTH (DEPTH),
        .LINE  (LINE),
        .WIN   (WIN)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (redir_i),
        .wr_en_i   (wr_en),
        .wr_off_i  (wr_off),
        .wr_data_i (ic_rdata_i),
        .take_i    (take_eff),
        .count_o   (count),
        .win_o     (win_o)
    );

    // R5: a redirect leaves the queue empty
    a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |=> (avail_o == '0));

endmodule

// File: tb/prefetch_queue_bench.sv
`timescale 1ns/1ps
module prefetch_queue_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         redir_i = 1'b0;
    logic [31:0]  redir_addr_i = '0;
    logic         data_pend_i = 1'b0;
    logic         ic_req_o;
    logic [31:0]  ic_addr_o;
    logic         ic_busy_i = 1'b0;
    logic         ic_rvalid_i = 1'b0;
    logic [127:0] ic_rdata_i = '0;
    logic [5:0]   avail_o;
    logic [63:0]  win_o;
    logic [3:0]   take_i = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    prefetch_queue u_prefetch_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .redir_i      (redir_i),
        .redir_addr_i (redir_addr_i),
        .data_pend_i  (data_pend_i),
        .ic_req_o     (ic_req_o),
        .ic_addr_o    (ic_addr_o),
        .ic_busy_i    (ic_busy_i),
        .ic_rvalid_i  (ic_rvalid_i),
        .ic_rdata_i   (ic_rdata_i),
        .avail_o      (avail_o),
        .win_o        (win_o),
        .take_i       (take_i)
    );

    // Behavioural reference state
    byte unsigned mq[$];
    int           m_state = 0;   // 0 idle, 1 target retry, 2 streaming
    logic [31:0]  m_faddr = '0;
    int           m_toff = 0;
    bit           m_slot = 0;
    bit           m_infl = 0;
    int           m_ioff = 0;
    logic [31:0]  m_iaddr = '0;
    int           m_rd = 0;
    bit           prev_hold = 0;
    logic [31:0]  prev_addr = '0;

    function automatic logic [127:0] blk_data(input logic [31:0] a);
        logic [127:0] d;
        for (int j = 0; j < 16; j++) begin
            d[8*j +: 8] = 8'(a[11:4] * 8'd37 + 8'(j) * 8'd11 + a[19:12]);
        end
        return d;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit rd, input logic [31:0] ra, input bit dp, input bit bz, input int want);
        bit          exp_req;
        logic [31:0] exp_addr;
        int          eoff;
        int          tk;
        int          nwin;
        string       rtag;
        string       atag;
        logic [127:0] d;
        @(negedge clk);
        tk = rd ? 0 : ((want > mq.size()) ? mq.size() : want);
        redir_i      = rd;
        redir_addr_i = ra;
        data_pend_i  = dp;
        ic_busy_i    = bz;
        take_i       = 4'(tk);
        ic_rvalid_i  = m_infl;
        ic_rdata_i   = blk_data(m_iaddr);
        if (rd) begin
            exp_req  = 1'b1;
            exp_addr = {ra[31:4], 4'h0};
            eoff     = int'(ra[3:0]);
            rtag     = "R5";
            atag     = "R5";
        end else begin
            exp_addr = m_faddr;
            eoff     = (m_state == 1) ? m_toff : 0;
            atag     = (m_state == 1) ? "R10" : "R2";
            if (m_state == 0) begin
                exp_req = 1'b0; rtag = "R11";
            end else if (m_slot) begin
                exp_req = 1'b0; rtag = "R4";
            end else if (m_state == 1) begin
                exp_req = 1'b1; rtag = "R10";
            end else begin
                exp_req = (32 - mq.size() - (m_infl ? 16 - m_ioff : 0)) >= 16;
                rtag = "R3";
            end
        end
        #1;
        chk(rtag, 64'(ic_req_o), 64'(exp_req));
        if (exp_req) chk(atag, 64'(ic_addr_o), 64'(exp_addr));
        if (prev_hold && !rd && exp_req) chk("R9", 64'(ic_addr_o), 64'(prev_addr));
        chk("R6", 64'(avail_o), 64'(mq.size()));
        nwin = (mq.size() < 8) ? mq.size() : 8;
        for (int k = 0; k < nwin; k++) begin
            chk(((m_rd % 32) + k >= 32) ? "R8" : "R7", 64'(win_o[8*k +: 8]), 64'(mq[k]));
        end
        // advance reference
        if (rd) begin
            mq.delete();
            m_rd    = 0;
            m_faddr = exp_addr;
            m_toff  = eoff;
            m_infl  = 0;
            if (!bz) begin
                m_infl  = 1; m_ioff = eoff; m_iaddr = exp_addr;
                m_faddr = exp_addr + 32'd16;
                m_state = 2;
            end else begin
                m_state = 1;
            end
        end else begin
            for (int k = 0; k < tk; k++) void'(mq.pop_front());
            m_rd += tk;
            if (m_infl) begin
                d = blk_data(m_iaddr);
                for (int j = m_ioff; j < 16; j++) mq.push_back(d[8*j +: 8]);
            end
            m_infl = 0;
            if (exp_req && !bz) begin
                m_infl  = 1; m_ioff = eoff; m_iaddr = exp_addr;
                m_faddr = exp_addr + 32'd16;
                m_state = 2;
            end
        end
        m_slot    = dp;
        prev_hold = exp_req && bz;
        prev_addr = exp_addr;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", 64'(avail_o), 64'd0);
        chk("R1", 64'(ic_req_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", 64'(avail_o), 64'd0);
        chk("R1", 64'(ic_req_o), 64'd0);

        // R11: nothing fetched before a redirect
        repeat (5) step(0, 32'h0, 0, 0, 0);

        // aligned start, decoder stalled: queue fills and stops (R3)
        step(1, 32'h0000_1000, 0, 0, 0);
        repeat (10) step(0, 32'h0, 0, 0, 0);
        chk("R3", 64'(avail_o), 64'd32);

        // streaming with varying consumption
        repeat (200) step(0, 32'h0, 0, 0, $urandom_range(0, 8));
        repeat (100) step(0, 32'h0, 0, 0, 8);

        // announced data cycles (R4)
        repeat (200) step(0, 32'h0, ($urandom_range(0, 1) == 1), 0, $urandom_range(0, 8));

        // busy port (R9)
        repeat (200) step(0, 32'h0, 0, ($urandom_range(0, 9) < 3), $urandom_range(0, 8));

        // unaligned target: 16-7 = 9 bytes from the first line (R6)
        step(1, 32'h0000_22A7, 0, 0, 5);
        step(0, 32'h0, 0, 0, 0);
        step(0, 32'h0, 0, 0, 0);
        chk("R6", 64'(avail_o), 64'd9);
        repeat (20) step(0, 32'h0, 0, 0, 3);

        // redirect refused by a busy port, then retried (R10)
        step(1, 32'h0000_33F5, 0, 1, 0);
        step(0, 32'h0, 1, 1, 0);
        step(0, 32'h0, 0, 1, 0);
        chk("R10", 64'(ic_addr_o), 64'h33F0);
        step(0, 32'h0, 0, 0, 0);
        step(0, 32'h0, 0, 0, 0);
        chk("R10", 64'(ic_addr_o), 64'h3400);
        repeat (10) step(0, 32'h0, 0, 0, 4);

        // redirect while a line is returning: stale line dropped (R5)
        step(1, 32'h0000_4000, 0, 0, 0);
        step(1, 32'h0000_500F, 0, 0, 0);
        step(0, 32'h0, 0, 0, 0);
        chk("R5", 64'(avail_o), 64'd0);
        step(0, 32'h0, 0, 0, 0);
        chk("R6", 64'(avail_o), 64'd1);

        // mixed random traffic with occasional redirects
        for (int n = 0; n < 2500; n++) begin
            bit rd;
            rd = ($urandom_range(0, 99) < 3);
            step(rd, $urandom, ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0),
                 $urandom_range(0, 8));
        end

        summary();
        $finish;
    end

endmodule